// File: doc/BRIEF.md
# I2C Bus Timing Generator

This block produces the SCL level and the SDA change points for an I2C master. A transaction engine next to it asks for one bus element at a time: a START, a repeated START, a single data or acknowledge bit, or a STOP. The generator then walks through the phases of that element and answers with a one-cycle done strobe. Every phase length is counted in pulses of a baud-rate tick enable, one system-clock cycle wide. The lengths come from programmed fields, so one netlist covers standard, fast and fast-plus rates with different settings.

The SCL and SDA outputs are levels: 1 means the line is released and 0 means it is driven low. The sampled bus levels come back on `scl_in` and `sda_in`. After the generator releases SCL, it waits a programmed number of system-clock cycles. It then checks that the bus really shows SCL high before it starts timing the high phase. A target that stretches the clock therefore lengthens the high phase instead of cutting it short. An acknowledge bit uses the same bit request as a data bit. The engine drives 0 to acknowledge, or 1 to release SDA and read the target's answer on `rx_bit`.

Top module: `i2c_bus_timer`

## Requirements
- R1: After reset, `scl_out` and `sda_out` are 1 (released) and `done` is 0.
- R2: `req_op` = 0 (START) is issued from an idle bus with both lines high. SDA goes low on the accept edge while SCL stays high. After the first-START hold ticks (`cfg_data_timing[31:24]`), SCL goes low and `done` pulses.
- R3: `req_op` = 2 (bit) starts with SCL low. SDA keeps its previous level for the data-hold ticks (`cfg_data_timing[7:0]`) and then takes `req_bit`. SCL then stays low for the low-period ticks (`cfg_bus_clk[7:0]`).
- R4: During a bit, after the low period SCL is released and held high for the high-period ticks (`cfg_bus_clk[15:8]`). SCL then goes low on the same edge as the `done` pulse, and `rx_bit` returns the `sda_in` level sampled at the end of the high phase.
- R5: `req_op` = 1 (repeated START) follows the data-hold ticks. SDA is released for the low-period ticks, then SCL is released. After the setup ticks (`cfg_data_timing[15:8]`), SDA falls. After the hold ticks (`cfg_rs_hold`), SCL falls and `done` pulses.
- R6: `req_op` = 3 (STOP) follows the data-hold ticks. SDA is driven low for the low-period ticks, then SCL is released. After the STOP setup ticks (`cfg_data_timing[23:16]`), SDA is released and `done` pulses, with SCL left high.
- R7: After SCL is released, ticks in the high or setup phase are counted only once `cfg_sync_cycles` system-clock cycles have passed and `scl_in` has been seen high. While a target holds `scl_in` low, `scl_out` stays released.
- R8: A programmed tick field or sync count of 0 acts as 1.
- R9: `done` is a single-cycle pulse per request. During a bit, SDA does not change while SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Baud tick enable, one clock wide |
| cfg_bus_clk | input | 2*TW | Bus clock word: high period [15:8], low period [7:0] |
| cfg_data_timing | input | 4*TW | START hold [31:24], STOP setup [23:16], repeated-START setup [15:8], data hold [7:0] |
| cfg_rs_hold | input | TW | Repeated-START hold ticks |
| cfg_sync_cycles | input | SYNC_W | Cycles to wait after releasing SCL before comparing |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 START, 1 repeated START, 2 bit, 3 STOP |
| req_bit | input | 1 | SDA level for a bit request |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_out | output | 1 | SCL drive: 1 released, 0 low |
| sda_out | output | 1 | SDA drive: 1 released, 0 low |
| done | output | 1 | Request finished |
| rx_bit | output | 1 | SDA sampled at end of the last bit's high phase |

## Verification
The bench logs each interval over which the two outputs hold one level pair, counting baud ticks under the same rules a bus observer would use. It compares that log against a phase list derived from the requirements. The main targets are the following cases:
- Stretched clocks longer than the sync window. A generator that counted during the stretch would shorten the observed high phase.
- Zero-valued fields. These would hang a plain down-counter or produce a zero-length phase.
- A data bit equal to the previous SDA level. Here a wrongly placed SDA change would not show, so the merged low interval is checked by its total length.
- Repeated STARTs and STOPs, whose SDA edges fall inside the SCL-high window.
- Bus-side reads on `rx_bit`, which catch a sample taken at the wrong edge or from the driven value instead of the bus.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

   typedef enum logic [1:0] {
      OP_START   = 2'd0,
      OP_RESTART = 2'd1,
      OP_BIT     = 2'd2,
      OP_STOP    = 2'd3
   } bt_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHOLD,
      ST_DHOLD,
      ST_LOW,
      ST_WAIT,
      ST_HIGH,
      ST_RHOLD
   } bt_state_e;

endpackage

// File: rtl/bt_phase_counter.sv
module bt_phase_counter #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          run,
   input  logic          tick_en,
   output logic          expire
);

   localparam logic [TW-1:0] ONE = TW'(1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ONE;
      end else if (load) begin
         cnt <= (load_val == '0) ? ONE : load_val;
      end else if (run && tick_en && cnt != ONE) begin
         cnt <= cnt - ONE;
      end
   end

   assign expire = run && tick_en && (cnt == ONE);

   AST_CNT_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0); // R8

endmodule

// File: rtl/bt_scl_gate.sv
module bt_scl_gate #(
   parameter int SYNC_W = 8,
   parameter int STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              en,
   input  logic [SYNC_W-1:0] sync_cycles,
   input  logic              scl_in,
   output logic              scl_seen,
   output logic              go
);

   localparam logic [SYNC_W-1:0] ONE = SYNC_W'(1);

   generate
      if (STAGES == 0) begin : g_direct
         assign scl_seen = scl_in;
      end else begin : g_sync
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= scl_in;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign scl_seen = sh[STAGES-1];
      end
   endgenerate

   logic [SYNC_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ONE;
      end else if (arm) begin
         cnt <= (sync_cycles == '0) ? ONE : sync_cycles;
      end else if (en && cnt != ONE) begin
         cnt <= cnt - ONE;
      end
   end

   assign go = en && (cnt == ONE) && scl_seen;

   AST_SYNC_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0); // R8

endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer
   import i2c_bt_pkg::*;
#(
   parameter int TW            = 8,
   parameter int SYNC_W        = 8,
   parameter int SCL_IN_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [2*TW-1:0]   cfg_bus_clk,
   input  logic [4*TW-1:0]   cfg_data_timing,
   input  logic [TW-1:0]     cfg_rs_hold,
   input  logic [SYNC_W-1:0] cfg_sync_cycles,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic              req_bit,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_out,
   output logic              sda_out,
   output logic              done,
   output logic              rx_bit
);

   generate
      if (TW < 2) begin : g_bad_tw
         $error("i2c_bus_timer: TW must be at least 2");
      end
      if (SYNC_W < 1) begin : g_bad_sync
         $error("i2c_bus_timer: SYNC_W must be at least 1");
      end
      if (SCL_IN_STAGES < 0) begin : g_bad_stages
         $error("i2c_bus_timer: SCL_IN_STAGES must not be negative");
      end
   endgenerate

   // field slices; positions are fixed by the configuration words
   logic [TW-1:0] f_low, f_high, f_hold, f_rs_setup, f_stop_setup, f_start_hold;
   assign f_low        = cfg_bus_clk[TW-1:0];
   assign f_high       = cfg_bus_clk[2*TW-1:TW];
   assign f_hold       = cfg_data_timing[TW-1:0];
   assign f_rs_setup   = cfg_data_timing[2*TW-1:TW];
   assign f_stop_setup = cfg_data_timing[3*TW-1:2*TW];
   assign f_start_hold = cfg_data_timing[4*TW-1:3*TW];

   bt_state_e state, state_n;
   bt_op_e    op_q, op_cur;
   logic      bit_q;
   logic      scl_q, scl_n, sda_q, sda_n, done_q, done_n, rx_q, rx_n;
   logic      accept, expire, go, scl_seen;
   logic      ph_load, ph_run, gate_arm, gate_en;
   logic [TW-1:0] ph_val;

   assign accept = (state == ST_IDLE) && req_valid;
   assign op_cur = accept ? bt_op_e'(req_op) : op_q;

   always_comb begin
      state_n = state;
      scl_n   = scl_q;
      sda_n   = sda_q;
      done_n  = 1'b0;
      rx_n    = rx_q;
      case (state)
         ST_IDLE: begin
            if (req_valid) begin
               if (op_cur == OP_START) begin
                  sda_n   = 1'b0;
                  state_n = ST_SHOLD;
               end else begin
                  state_n = ST_DHOLD;
               end
            end
         end
         ST_SHOLD: begin
            if (expire) begin
               scl_n   = 1'b0;
               done_n  = 1'b1;
               state_n = ST_IDLE;
            end
         end
         ST_DHOLD: begin
            if (expire) begin
               case (op_q)
                  OP_BIT:     sda_n = bit_q;
                  OP_RESTART: sda_n = 1'b1;
                  default:    sda_n = 1'b0;
               endcase
               state_n = ST_LOW;
            end
         end
         ST_LOW: begin
            if (expire) begin
               scl_n   = 1'b1;
               state_n = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (go) state_n = ST_HIGH;
         end
         ST_HIGH: begin
            if (expire) begin
               case (op_q)
                  OP_BIT: begin
                     rx_n    = sda_in;
                     scl_n   = 1'b0;
                     done_n  = 1'b1;
                     state_n = ST_IDLE;
                  end
                  OP_RESTART: begin
                     sda_n   = 1'b0;
                     state_n = ST_RHOLD;
                  end
                  default: begin
                     sda_n   = 1'b1;
                     done_n  = 1'b1;
                     state_n = ST_IDLE;
                  end
               endcase
            end
         end
         ST_RHOLD: begin
            if (expire) begin
               scl_n   = 1'b0;
               done_n  = 1'b1;
               state_n = ST_IDLE;
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_comb begin
      case (state_n)
         ST_SHOLD: ph_val = f_start_hold;
         ST_DHOLD: ph_val = f_hold;
         ST_LOW:   ph_val = f_low;
         ST_RHOLD: ph_val = cfg_rs_hold;
         ST_WAIT, ST_HIGH: begin
            case (op_q)
               OP_RESTART: ph_val = f_rs_setup;
               OP_STOP:    ph_val = f_stop_setup;
               default:    ph_val = f_high;
            endcase
         end
         default: ph_val = '0;
      endcase
   end

   assign ph_load  = (state_n != state);
   assign ph_run   = (state == ST_SHOLD) || (state == ST_DHOLD) || (state == ST_LOW) ||
                     (state == ST_HIGH)  || (state == ST_RHOLD);
   assign gate_arm = (state_n == ST_WAIT) && (state != ST_WAIT);
   assign gate_en  = (state == ST_WAIT);

   bt_phase_counter #(.TW(TW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .run      (ph_run),
      .tick_en  (tick_en),
      .expire   (expire)
   );

   bt_scl_gate #(.SYNC_W(SYNC_W), .STAGES(SCL_IN_STAGES)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (gate_arm),
      .en          (gate_en),
      .sync_cycles (cfg_sync_cycles),
      .scl_in      (scl_in),
      .scl_seen    (scl_seen),
      .go          (go)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         op_q   <= OP_START;
         bit_q  <= 1'b1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
         done_q <= 1'b0;
         rx_q   <= 1'b0;
      end else begin
         state  <= state_n;
         scl_q  <= scl_n;
         sda_q  <= sda_n;
         done_q <= done_n;
         rx_q   <= rx_n;
         if (accept) begin
            op_q  <= op_cur;
            bit_q <= req_bit;
         end
      end
   end

   assign scl_out = scl_q;
   assign sda_out = sda_q;
   assign done    = done_q;
   assign rx_bit  = rx_q;

   AST_STRETCH_KEEPS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !scl_seen) |=> scl_out); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_BIT && (state == ST_WAIT || state == ST_HIGH)) |=> $stable(sda_out)); // R9
   AST_SCL_FALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_out) |-> done); // R4
   AST_START_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHOLD) |-> (scl_out && !sda_out)); // R2

endmodule

// File: tb/i2c_bus_timer_tb.sv
module i2c_bus_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int MAXSEG     = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic [7:0] c_lo, c_hi, c_sh, c_ss, c_rss, c_dh, c_rsh, c_syn;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic req_bit = 1'b1;
   logic scl_in, sda_in, scl_out, sda_out, done, rx_bit;
   logic slave_sda = 1'b1;

   int stretch_left = 0;
   int stretch_cfg  = 0;
   int tick_pct     = 50;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   string tag_extra = "";

   int lg_scl[MAXSEG], lg_sda[MAXSEG], lg_t[MAXSEG];
   int lg_n = 0;
   int e_scl[MAXSEG], e_sda[MAXSEG], e_t[MAXSEG];
   int e_n = 0;

   logic [1:0] prev_cfg = 2'b11;
   int seg = 0;
   int kcyc = 0;
   bit armed = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_in = scl_out && (stretch_left == 0);
   assign sda_in = sda_out && slave_sda;

   i2c_bus_timer dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .tick_en         (tick_en),
      .cfg_bus_clk     ({c_hi, c_lo}),
      .cfg_data_timing ({c_sh, c_ss, c_rss, c_dh}),
      .cfg_rs_hold     (c_rsh),
      .cfg_sync_cycles (c_syn),
      .req_valid       (req_valid),
      .req_op          (req_op),
      .req_bit         (req_bit),
      .scl_in          (scl_in),
      .sda_in          (sda_in),
      .scl_out         (scl_out),
      .sda_out         (sda_out),
      .done            (done),
      .rx_bit          (rx_bit)
   );

   function automatic int nz(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   // bus observer: logs each interval of constant output levels with its tick count
   always @(negedge clk) begin
      int sync_eff;
      bit bus_hi;
      #2;
      sync_eff = nz(int'(c_syn));
      tick_en = ($urandom_range(99) < tick_pct);
      if ({scl_out, sda_out} != prev_cfg) begin
         if (seg > 0 && lg_n < MAXSEG) begin
            lg_scl[lg_n] = prev_cfg[1];
            lg_sda[lg_n] = prev_cfg[0];
            lg_t[lg_n]   = seg;
            lg_n++;
         end
         seg = 0;
         if (scl_out && !prev_cfg[1]) begin
            stretch_left = stretch_cfg;
            kcyc  = 0;
            armed = 1'b0;
         end
         prev_cfg = {scl_out, sda_out};
      end else if (scl_out && stretch_left > 0) begin
         stretch_left--;
      end
      bus_hi = scl_out && (stretch_left == 0);
      if (req_valid) begin
         seg   = 0;
         armed = scl_out;
         kcyc  = 0;
      end else begin
         if (tick_en && (!scl_out || armed)) seg++;
         if (scl_out && !armed) begin
            kcyc++;
            if (kcyc >= sync_eff && bus_hi) armed = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   task automatic add_exp(input int s, input int d, input int t);
      if (e_n > 0 && e_scl[e_n-1] == s && e_sda[e_n-1] == d) begin
         e_t[e_n-1] += t;
      end else if (e_n < MAXSEG) begin
         e_scl[e_n] = s; e_sda[e_n] = d; e_t[e_n] = t;
         e_n++;
      end
   endtask

   // op: 0 START, 1 repeated START, 2 bit, 3 STOP
   task automatic build_exp(input int op, input int old_sda, input int b);
      e_n = 0;
      case (op)
         0: add_exp(1, 0, nz(c_sh));
         1: begin
            add_exp(0, old_sda, nz(c_dh)); add_exp(0, 1, nz(c_lo));
            add_exp(1, 1, nz(c_rss));      add_exp(1, 0, nz(c_rsh));
         end
         2: begin
            add_exp(0, old_sda, nz(c_dh)); add_exp(0, b, nz(c_lo));
            add_exp(1, b, nz(c_hi));
         end
         default: begin
            add_exp(0, old_sda, nz(c_dh)); add_exp(0, 0, nz(c_lo));
            add_exp(1, 0, nz(c_ss));
         end
      endcase
   endtask

   task automatic do_op(input int op, input int b, input int slave, input int max_stretch);
      string tag;
      int wait_cyc;
      int bad;
      case (op)
         0: tag = "R2";
         1: tag = "R5";
         2: tag = "R3 R4";
         default: tag = "R6";
      endcase
      tag = {tag, tag_extra};
      @(negedge clk); #1;
      build_exp(op, int'(sda_out), b);
      stretch_cfg = (max_stretch > 0) ? $urandom_range(max_stretch) : 0;
      slave_sda = (op == 2) ? slave[0] : 1'b1;
      lg_n = 0;
      req_op = 2'(op);
      req_bit = b[0];
      req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
      wait_cyc = 0;
      while (!done && wait_cyc < 60000) begin
         @(negedge clk); #1;
         wait_cyc++;
      end
      if (!done) begin
         chk(1'b0, tag, "no done strobe", 0, 1);
         return;
      end
      #2;
      bad = -1;
      if (lg_n != e_n) begin
         chk(1'b0, tag, "phase count", lg_n, e_n);
      end else begin
         for (int i = 0; i < e_n; i++)
            if (bad < 0 && (lg_scl[i] != e_scl[i] || lg_sda[i] != e_sda[i] || lg_t[i] != e_t[i])) bad = i;
         if (bad >= 0)
            chk(1'b0, tag, $sformatf("phase %0d scl/sda/ticks act=%0d/%0d", bad, lg_scl[bad], lg_sda[bad]),
                lg_t[bad], e_t[bad]);
         else
            chk(1'b1, tag, "phases", 0, 0);
      end
      if (op == 2) chk(int'(rx_bit) == (b & slave), {"R4", tag_extra}, "rx_bit", int'(rx_bit), b & slave);
      @(negedge clk); #1;
      chk(done == 1'b0, {"R9", tag_extra}, "done width", int'(done), 0);
      slave_sda = 1'b1;
   endtask

   task automatic run_txn(input int nbits, input bit with_rs, input int max_stretch);
      do_op(0, 0, 1, max_stretch);
      for (int i = 0; i < nbits; i++)
         do_op(2, $urandom_range(1), $urandom_range(1), max_stretch);
      if (with_rs) begin
         do_op(1, 0, 1, max_stretch);
         for (int i = 0; i < 2; i++)
            do_op(2, $urandom_range(1), $urandom_range(1), max_stretch);
      end
      do_op(3, 0, 1, max_stretch);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "R9", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      void'($urandom(32'h5a17));
      c_lo = 8'd156; c_hi = 8'd154; c_sh = 8'd23; c_ss = 8'd150;
      c_rss = 8'd156; c_dh = 8'd12; c_rsh = 8'd150; c_syn = 8'd4;
      repeat (5) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      chk(scl_out == 1'b1, "R1", "scl after reset", int'(scl_out), 1);
      chk(sda_out == 1'b1, "R1", "sda after reset", int'(sda_out), 1);
      chk(done == 1'b0, "R1", "done after reset", int'(done), 0);

      // directed: standard-rate settings, bits equal and unequal to prior SDA
      tick_pct = 50;
      do_op(0, 0, 1, 0);
      do_op(2, 0, 1, 0);
      do_op(2, 1, 0, 0);
      do_op(2, 1, 1, 0);
      do_op(1, 0, 1, 0);
      do_op(2, 0, 1, 0);
      do_op(3, 0, 1, 0);

      // directed: every field zero acts as one tick
      tag_extra = " R8";
      c_lo = 0; c_hi = 0; c_sh = 0; c_ss = 0; c_rss = 0; c_dh = 0; c_rsh = 0; c_syn = 0;
      tick_pct = 100;
      run_txn(3, 1'b1, 0);
      tick_pct = 40;
      run_txn(2, 1'b1, 0);

      // directed: clock stretching longer than the sync window
      tag_extra = " R7";
      c_lo = 5; c_hi = 6; c_sh = 3; c_ss = 4; c_rss = 5; c_dh = 2; c_rsh = 3; c_syn = 2;
      tick_pct = 60;
      run_txn(4, 1'b1, 14);

      // random settings, tick densities and stretch lengths
      tag_extra = "";
      for (int t = 0; t < 25; t++) begin
         c_lo = 8'($urandom_range(15)); c_hi = 8'($urandom_range(15));
         c_sh = 8'($urandom_range(15)); c_ss = 8'($urandom_range(15));
         c_rss = 8'($urandom_range(15)); c_dh = 8'($urandom_range(15));
         c_rsh = 8'($urandom_range(15)); c_syn = 8'($urandom_range(6));
         tick_pct = $urandom_range(100, 20);
         run_txn($urandom_range(4, 1), 1'($urandom_range(1)), $urandom_range(8));
      end
      summary();
   end

endmodule